// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits beside a processor core and decides when an interrupt is taken. It watches a vector of pending request lines together with a global interrupt enable bit that it owns. The core tells it when an instruction has finished, when a return-from-interrupt executes, and when software sets or clears the global enable. On an instruction boundary the block picks the pending request with the smallest index, since index 0 is the top priority. It then emits a one-cycle take pulse, the chosen index, the vector address and a one-hot acknowledge that the requesting source uses to drop its flag.

Priority matters only when several requests are pending at the same moment. Taking an interrupt clears the global enable, so a handler cannot be interrupted unless software enables interrupts again. A return sets the enable again, but the next instruction boundary is consumed before any further interrupt can be taken. This guarantees forward progress for the interrupted code. Each vector slot is two words wide. The table base is either address 0 or a boot-area start address, chosen by a select input. The core itself pushes and pops the return address and fetches from the vector.

Top module: `prio_vector_unit`

## Requirements
- R1: When several request lines are pending on a taken boundary, the lowest-indexed line is taken. The rest are not acknowledged and can be taken later.
- R2: A request is only taken in the cycle an instruction-boundary strobe is high. Without that strobe nothing is taken, whatever the requests and the enable.
- R3: A take gives `takePulse` high for exactly one cycle, one cycle after the boundary. In that same cycle `ackOneHot` has only bit `takeIndex` set (bit i acknowledges line i) and `globalEnable` reads 0. At all other times `ackOneHot` is zero.
- R4: While `globalEnable` is 0, no request is taken, not even line 0.
- R5: The set-enable strobe makes `globalEnable` 1 and the clear-enable strobe makes it 0, both from the next cycle. Their precedence, highest first, is: take (forces 0), return (forces 1), clear, set.
- R6: A return strobe sets `globalEnable` and arms a holdoff. A boundary in the same cycle as the return takes nothing. The first boundary after the return takes nothing and clears the holdoff. A later boundary can take.
- R7: `vectorAddr` equals the base plus 2 × `takeIndex`, computed modulo 2^ADDR_W. The base is 0 when `bootSelect` is 0 and `BOOT_BASE` when it is 1. `bootSelect` is sampled on the boundary that takes.
- R8: During and right after reset, `globalEnable` is 0, the holdoff is inactive, and `takePulse`, `ackOneHot`, `takeIndex` and `vectorAddr` are all zero.
- R9: A request line that stays pending after a higher-priority line was taken is taken on a later eligible boundary, with its own index and address.
- R10: `takeIndex` and `vectorAddr` keep their last values between takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPending | input | NUM_REQ | Pending request flags, bit 0 highest priority |
| instrBoundary | input | 1 | An instruction completed this cycle |
| retStrobe | input | 1 | Return-from-interrupt executed |
| seiStrobe | input | 1 | Software sets the global enable |
| cliStrobe | input | 1 | Software clears the global enable |
| bootSelect | input | 1 | 1 selects the boot-area vector base |
| takePulse | output | 1 | One-cycle interrupt-taken pulse |
| takeIndex | output | IDX_W | Index of the taken line |
| vectorAddr | output | ADDR_W | Word address of the taken vector slot |
| ackOneHot | output | NUM_REQ | One-hot acknowledge to the taken source |
| globalEnable | output | 1 | Global interrupt enable bit |

## Verification
Every result of this block is registered, so each one is due one clock edge after the stimulus that causes it. That covers the take pulse, the acknowledge, the index, the address and the enable bit after a set, clear, return or take. The bench drives each stimulus on the falling edge and samples all outputs 2 ns after the next rising edge. A cycle-level reference model updates the expected enable and holdoff at that same edge. The holdoff has no output of its own, so it is judged by whether the boundaries after a return produce a take.

// File: rtl/pvu_pkg.sv
package pvu_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture winner index, address and acknowledge
  } pvuStrobes_t;

endpackage

// File: rtl/pvu_control.sv
module pvu_control
  import pvu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        instrBoundary,
  input  logic        retStrobe,
  input  logic        seiStrobe,
  input  logic        cliStrobe,
  output pvuStrobes_t strobes,
  output logic        takePulse,
  output logic        globalEnable
);

  logic holdoff;
  logic takeNow;

  // Eligible only on a boundary, enabled, outside holdoff, not on a return.
  assign takeNow = instrBoundary && globalEnable && !holdoff && !retStrobe && anyReq;
  assign strobes.load = takeNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEnable <= 1'b0;
      holdoff      <= 1'b0;
      takePulse    <= 1'b0;
    end else begin
      takePulse <= takeNow;
      if (takeNow)        globalEnable <= 1'b0;
      else if (retStrobe) globalEnable <= 1'b1;
      else if (cliStrobe) globalEnable <= 1'b0;
      else if (seiStrobe) globalEnable <= 1'b1;
      if (retStrobe)          holdoff <= 1'b1;
      else if (instrBoundary) holdoff <= 1'b0;
    end
  end

  assert_take_clears_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |-> !globalEnable);
  assert_single_cycle_take_R3: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |=> !takePulse);
  assert_take_on_boundary_R2: assert property (@(posedge clk) disable iff (!rstN)
    !instrBoundary |=> !takePulse);
  assert_blocked_when_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !globalEnable |=> !takePulse);
  assert_no_take_after_return_R6: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |=> !takePulse);

endmodule

// File: rtl/pvu_datapath.sv
module pvu_datapath
  import pvu_pkg::*;
#(
  parameter int NUM_REQ    = 32,
  parameter int ADDR_W     = 16,
  parameter int SLOT_LOG2  = 1,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqPending,
  input  logic               bootSelect,
  input  pvuStrobes_t        strobes,
  output logic               anyReq,
  output logic [IDX_W-1:0]   takeIndex,
  output logic [ADDR_W-1:0]  vectorAddr,
  output logic [NUM_REQ-1:0] ackOneHot
);

  logic [IDX_W-1:0]   winIdx;
  logic [NUM_REQ-1:0] winDecode;
  logic [ADDR_W-1:0]  baseAddr;
  logic [ADDR_W-1:0]  nextAddr;

  assign anyReq = |reqPending;

  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (reqPending[i]) winIdx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : gDecode
    assign winDecode[g] = (winIdx == IDX_W'(g));
  end

  assign baseAddr = bootSelect ? BOOT_BASE : '0;
  assign nextAddr = baseAddr + (ADDR_W'(winIdx) << SLOT_LOG2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIndex  <= '0;
      vectorAddr <= '0;
      ackOneHot  <= '0;
    end else begin
      ackOneHot <= strobes.load ? winDecode : '0;
      if (strobes.load) begin
        takeIndex  <= winIdx;
        vectorAddr <= nextAddr;
      end
    end
  end

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOneHot));
  assert_ack_matches_index_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ackOneHot != '0) |-> ackOneHot[takeIndex]);
  assert_ack_was_pending_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> ((ackOneHot & $past(reqPending)) != '0));
  assert_index_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(takeIndex) && $stable(vectorAddr)));

endmodule

// File: rtl/prio_vector_unit.sv
module prio_vector_unit
  import pvu_pkg::*;
#(
  parameter int NUM_REQ    = 32,
  parameter int ADDR_W     = 16,
  parameter int SLOT_LOG2  = 1,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqPending,
  input  logic               instrBoundary,
  input  logic               retStrobe,
  input  logic               seiStrobe,
  input  logic               cliStrobe,
  input  logic               bootSelect,
  output logic               takePulse,
  output logic [IDX_W-1:0]   takeIndex,
  output logic [ADDR_W-1:0]  vectorAddr,
  output logic [NUM_REQ-1:0] ackOneHot,
  output logic               globalEnable
);

  pvuStrobes_t strobes;
  logic        anyReq;

  pvu_control uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .anyReq        (anyReq),
    .instrBoundary (instrBoundary),
    .retStrobe     (retStrobe),
    .seiStrobe     (seiStrobe),
    .cliStrobe     (cliStrobe),
    .strobes       (strobes),
    .takePulse     (takePulse),
    .globalEnable  (globalEnable)
  );

  pvu_datapath #(
    .NUM_REQ   (NUM_REQ),
    .ADDR_W    (ADDR_W),
    .SLOT_LOG2 (SLOT_LOG2),
    .BOOT_BASE (BOOT_BASE)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .reqPending (reqPending),
    .bootSelect (bootSelect),
    .strobes    (strobes),
    .anyReq     (anyReq),
    .takeIndex  (takeIndex),
    .vectorAddr (vectorAddr),
    .ackOneHot  (ackOneHot)
  );

  // R8: outputs quiet in the first cycle after reset release
  assert_quiet_after_reset_R8: assert property (@(posedge clk)
    $rose(rstN) |-> (!takePulse && ackOneHot == '0 && !globalEnable));

endmodule

// File: tb/prio_vector_unit_test.sv
module prio_vector_unit_test;

  localparam int NUM_REQ = 32;
  localparam int ADDR_W  = 16;
  localparam logic [ADDR_W-1:0] BOOT_BASE = 16'hF000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_REQ-1:0] reqPending = '0;
  logic              instrBoundary = 1'b0, retStrobe = 1'b0;
  logic              seiStrobe = 1'b0, cliStrobe = 1'b0, bootSelect = 1'b0;
  logic              takePulse, globalEnable;
  logic [4:0]        takeIndex;
  logic [ADDR_W-1:0] vectorAddr;
  logic [NUM_REQ-1:0] ackOneHot;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit               mGe = 0, mHold = 0;
  logic [4:0]        mIdx = '0;
  logic [ADDR_W-1:0] mAddr = '0;
  logic [NUM_REQ-1:0] srcReq = '0;

  always #4 clk = ~clk;

  prio_vector_unit #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .SLOT_LOG2(1), .BOOT_BASE(BOOT_BASE)) uut (
    .clk(clk), .rstN(rstN), .reqPending(reqPending), .instrBoundary(instrBoundary),
    .retStrobe(retStrobe), .seiStrobe(seiStrobe), .cliStrobe(cliStrobe),
    .bootSelect(bootSelect), .takePulse(takePulse), .takeIndex(takeIndex),
    .vectorAddr(vectorAddr), .ackOneHot(ackOneHot), .globalEnable(globalEnable));

  function automatic logic [4:0] lowestIdx(input logic [NUM_REQ-1:0] r);
    for (int i = 0; i < NUM_REQ; i++) if (r[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [ADDR_W-1:0] slotAddr(input logic [4:0] idx, input bit boot);
    return (boot ? BOOT_BASE : '0) + ADDR_W'({idx, 1'b0});
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // One cycle: drive at negedge, sample 2 ns after the following posedge.
  task automatic step(input logic [NUM_REQ-1:0] rq, input bit ib, input bit ret,
                      input bit sei, input bit cli, input bit boot, input string tag);
    bit expTake;
    logic [NUM_REQ-1:0] expAck;
    @(negedge clk);
    reqPending = rq; instrBoundary = ib; retStrobe = ret;
    seiStrobe = sei; cliStrobe = cli; bootSelect = boot;
    expTake = ib && mGe && !mHold && !ret && (rq != '0);
    expAck = '0;
    if (expTake) begin
      mIdx  = lowestIdx(rq);
      mAddr = slotAddr(mIdx, boot);
      expAck[mIdx] = 1'b1;
    end
    if (expTake)  mGe = 0;
    else if (ret) mGe = 1;
    else if (cli) mGe = 0;
    else if (sei) mGe = 1;
    if (ret)     mHold = 1;
    else if (ib) mHold = 0;
    @(posedge clk); #2;
    check(tag, "takePulse R3", 32'(takePulse), 32'(expTake));
    check(tag, "globalEnable R5", 32'(globalEnable), 32'(mGe));
    check(tag, "ackOneHot R3", ackOneHot, expAck);
    check(tag, "takeIndex R1 R10", 32'(takeIndex), 32'(mIdx));
    check(tag, "vectorAddr R7 R10", 32'(vectorAddr), 32'(mAddr));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(posedge clk);
    #2;
    check("R8", "takePulse", 32'(takePulse), 0);
    check("R8", "globalEnable", 32'(globalEnable), 0);
    check("R8", "ackOneHot", ackOneHot, 0);
    check("R8", "vectorAddr", 32'(vectorAddr), 0);
    @(negedge clk); rstN = 1'b1;

    step(32'h88, 1, 0, 0, 0, 0, "R4");          // disabled after reset: no take
    step(32'h88, 0, 0, 1, 0, 0, "R5");          // set enable
    step(32'h88, 0, 0, 0, 0, 0, "R2");          // no boundary: no take
    step(32'h88, 1, 0, 0, 0, 0, "R1");          // take 3, address 6
    step(32'h80, 1, 0, 0, 0, 0, "R4");          // enable cleared by take
    step(32'h80, 1, 1, 0, 0, 0, "R6");          // return with boundary: no take
    step(32'h80, 1, 0, 0, 0, 1, "R6");          // first boundary after return
    step(32'h80, 1, 0, 0, 0, 1, "R9");          // take 7 from boot base
    step(32'h0,  0, 0, 0, 0, 0, "R10");         // values held
    step(32'h1,  0, 0, 1, 0, 0, "R5");
    step(32'h1,  0, 0, 1, 1, 0, "R5");          // clear beats set
    step(32'h1,  0, 0, 1, 0, 0, "R5");
    step(32'h1,  1, 0, 0, 1, 0, "R3");          // take beats clear, index 0
    step(32'h0,  0, 1, 0, 1, 0, "R6");          // return beats clear
    step(32'h80000000, 1, 0, 0, 0, 1, "R6");    // holdoff boundary
    step(32'h80000000, 1, 0, 0, 0, 1, "R7");    // take 31 at BOOT_BASE+62
    step(32'hFFFFFFFF, 0, 0, 1, 0, 0, "R5");
    step(32'hFFFFFFFE, 1, 0, 0, 0, 0, "R1");    // take 1
    step(32'h0, 0, 0, 1, 0, 0, "R5");
    step(32'h0, 1, 0, 0, 0, 0, "R2");           // no request, no take

    // constrained random with a source model that drops flags on acknowledge
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [NUM_REQ-1:0] rq;
      srcReq = srcReq & ~ackOneHot;
      if ($urandom_range(3) == 0) srcReq[$urandom_range(NUM_REQ-1)] = 1'b1;
      rq = srcReq;
      step(rq, $urandom_range(2) != 0, $urandom_range(15) == 0,
           $urandom_range(5) == 0, $urandom_range(11) == 0, $urandom_range(1) == 1, "R1");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule